// File: doc/BRIEF.md
# Standby Mode Power Controller

This block moves a small processor system between normal running and three standby states, and it drives the clock-enable lines for each clock domain. A decoded halt strobe goes to one of two halt depths, and a sticky option bit picks which one. A decoded sleep strobe always goes to the deepest state. An external master can also take the bus by raising a request line, if software has allowed bus release. This places the system in the shallow halt and raises a grant, and only dropping the request ends that halt.

Every other standby state ends when the wake condition is true. The wake condition is any enabled pending interrupt, or the level of any unmasked port-wake input, whatever trigger kind the port is set to elsewhere. After the deepest state, the CPU and bus clocks come back only after a programmable oscillator-settling count of fast-clock cycles. Four settings come from a small write-only register port: the slow-oscillator enable, the halt depth, the bus-release enable and the settling count.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: The `mode_o` codes are RUN=0, HALT=1, HALT2=2, SLEEP=3, SETTLE=4. With option word bit 0 (address 1) at 0, a halt strobe in RUN gives HALT on the next cycle. When the wake condition is true in a halt that an instruction entered, the next mode is RUN.
- R2: After synchronous reset, the mode is RUN and the option word bits are 0. The slow-oscillator enable is 1 and the settling count is `STAB_RST`.
- R3: In HALT only `en_cpu` is low. The bus unit, bus, DMA, fast oscillator, prescaler, peripheral and refresh enables stay high.
- R4: With option word bit 0 at 1, a halt strobe gives HALT2. In HALT2 the CPU, bus unit, bus, DMA and refresh enables are low, and the fast oscillator, prescaler and peripheral enables are high.
- R5: A sleep strobe in RUN gives SLEEP. In SLEEP every gating enable and the refresh enable are low.
- R6: In RUN, `bus_req` high with option word bit 1 at 1 gives HALT with `bus_gnt` high. The wake condition does not end this halt. `bus_req` going low gives RUN with `bus_gnt` low on the next cycle.
- R7: With option word bit 1 at 0, `bus_req` has no effect on the mode.
- R8: The wake condition is the OR of `irq_pend` and `port_lvl & port_msk`, taken as levels. A masked port level does not end standby.
- R9: Bit 0 of the power word (address 0) drives `en_sosc` in every mode. Writing 0 clears it.
- R10: When the wake condition is true in SLEEP and the settling count (address 2) is N>0, the mode is SETTLE for exactly N cycles and then RUN. In SETTLE the fast oscillator, prescaler and peripheral enables are high, and the CPU, bus unit, bus, DMA and refresh enables are low.
- R11: A halt or sleep strobe while the wake condition is true leaves the mode at RUN.
- R12: A sleep strobe and a halt strobe in the same cycle give SLEEP. With a settling count of 0, wake from SLEEP gives RUN directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| halt_stb | input | 1 | Decoded halt instruction strobe |
| sleep_stb | input | 1 | Decoded sleep instruction strobe |
| bus_req | input | 1 | External bus request, active high |
| irq_pend | input | IRQ_N | Enabled pending interrupts |
| port_lvl | input | PORT_N | Port wake input levels |
| port_msk | input | PORT_N | Port wake enables |
| en_cpu | output | 1 | CPU clock enable |
| en_bcu | output | 1 | Bus unit clock enable |
| en_bus | output | 1 | Bus clock enable |
| en_dma | output | 1 | DMA clock enable |
| en_fosc | output | 1 | Fast oscillator enable |
| en_presc | output | 1 | Prescaler enable |
| en_periph | output | 1 | Prescaled peripheral enable |
| en_refresh | output | 1 | Memory refresh enable |
| en_sosc | output | 1 | Slow oscillator and clock timer enable |
| bus_gnt | output | 1 | Bus granted to external master |
| mode_o | output | 3 | Current mode code |

## Verification
The properties assume that every input changes only between clock edges, and that strobes are single-cycle pulses seen in RUN. They also assume that a bus-request halt is ended only by dropping the request. The stimulus drives every input on the falling edge. It pulses each strobe for one cycle and holds `bus_req` steady for the whole bus-release episode. It also changes the option word only while the mode is RUN, so the depth chosen at each strobe is the one the property records.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        MD_RUN    = 3'd0,
        MD_HALT   = 3'd1,
        MD_HALT2  = 3'd2,
        MD_SLEEP  = 3'd3,
        MD_SETTLE = 3'd4
    } mode_e;

    typedef struct packed {
        logic cpu;
        logic bcu;
        logic bus;
        logic dma;
        logic fosc;
        logic presc;
        logic periph;
        logic refresh;
    } gate_t;

    localparam logic [1:0] ADR_PWR  = 2'd0;
    localparam logic [1:0] ADR_OPT  = 2'd1;
    localparam logic [1:0] ADR_STAB = 2'd2;

    localparam int OPT_DEEP_BIT = 0;
    localparam int OPT_BREL_BIT = 1;
    localparam int PWR_SOSC_BIT = 0;

    function automatic gate_t gates_for(mode_e m);
        gate_t g;
        g = '{default: 1'b1};
        case (m)
            MD_RUN:    g = '{default: 1'b1};
            MD_HALT:   g.cpu = 1'b0;
            MD_HALT2,
            MD_SETTLE: begin
                g.cpu     = 1'b0;
                g.bcu     = 1'b0;
                g.bus     = 1'b0;
                g.dma     = 1'b0;
                g.refresh = 1'b0;
            end
            MD_SLEEP:  g = '{default: 1'b0};
            default:   g = '{default: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/stby_cfg_regs.sv
module stby_cfg_regs
    import stby_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 16,
    parameter int STAB_W   = 16,
    parameter int STAB_RST = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sosc_on,
    output logic              halt_deep,
    output logic              brel_en,
    output logic [STAB_W-1:0] stab_len
);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(ADR_PWR);
    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(ADR_OPT);
    localparam logic [ADDR_W-1:0] A_STAB = ADDR_W'(ADR_STAB);

    always_ff @(posedge clk) begin
        if (rst) begin
            sosc_on   <= 1'b1;
            halt_deep <= 1'b0;
            brel_en   <= 1'b0;
            stab_len  <= STAB_W'(STAB_RST);
        end else if (wr_en) begin
            case (wr_addr)
                A_PWR:  sosc_on <= wr_data[PWR_SOSC_BIT];
                A_OPT: begin
                    halt_deep <= wr_data[OPT_DEEP_BIT];
                    brel_en   <= wr_data[OPT_BREL_BIT];
                end
                A_STAB: stab_len <= wr_data[STAB_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stby_wake.sv
module stby_wake #(
    parameter int IRQ_N  = 8,
    parameter int PORT_N = 4
) (
    input  logic [IRQ_N-1:0]  irq_pend,
    input  logic [PORT_N-1:0] port_lvl,
    input  logic [PORT_N-1:0] port_msk,
    output logic              wake
);
    logic [PORT_N-1:0] port_hit;

    for (genvar i = 0; i < PORT_N; i++) begin : g_port
        assign port_hit[i] = port_lvl[i] & port_msk[i];
    end

    assign wake = (|irq_pend) | (|port_hit);
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
#(
    parameter int STAB_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_stb,
    input  logic              sleep_stb,
    input  logic              bus_req,
    input  logic              brel_en,
    input  logic              halt_deep,
    input  logic              wake,
    input  logic [STAB_W-1:0] stab_len,
    output mode_e             mode,
    output logic              bus_gnt
);
    mode_e             mode_q, mode_d;
    logic              by_bus_q, by_bus_d;
    logic [STAB_W-1:0] ctr_q, ctr_d;

    always_comb begin
        mode_d   = mode_q;
        by_bus_d = by_bus_q;
        ctr_d    = ctr_q;
        case (mode_q)
            MD_RUN: begin
                if (bus_req && brel_en) begin
                    mode_d   = MD_HALT;
                    by_bus_d = 1'b1;
                end else if (!wake) begin
                    if (sleep_stb) begin
                        mode_d = MD_SLEEP;
                    end else if (halt_stb) begin
                        mode_d   = halt_deep ? MD_HALT2 : MD_HALT;
                        by_bus_d = 1'b0;
                    end
                end
            end
            MD_HALT: begin
                if (by_bus_q) begin
                    if (!bus_req) begin
                        mode_d   = MD_RUN;
                        by_bus_d = 1'b0;
                    end
                end else if (wake) begin
                    mode_d = MD_RUN;
                end
            end
            MD_HALT2: begin
                if (wake) mode_d = MD_RUN;
            end
            MD_SLEEP: begin
                if (wake) begin
                    if (stab_len == '0) begin
                        mode_d = MD_RUN;
                    end else begin
                        mode_d = MD_SETTLE;
                        ctr_d  = stab_len;
                    end
                end
            end
            MD_SETTLE: begin
                if (ctr_q <= STAB_W'(1)) begin
                    mode_d = MD_RUN;
                    ctr_d  = '0;
                end else begin
                    ctr_d = ctr_q - STAB_W'(1);
                end
            end
            default: begin
                mode_d   = MD_RUN;
                by_bus_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_RUN;
            by_bus_q <= 1'b0;
            ctr_q    <= '0;
        end else begin
            mode_q   <= mode_d;
            by_bus_q <= by_bus_d;
            ctr_q    <= ctr_d;
        end
    end

    assign mode    = mode_q;
    assign bus_gnt = by_bus_q;
endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
    import stby_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 16,
    parameter int STAB_W   = 16,
    parameter int STAB_RST = 16,
    parameter int IRQ_N    = 8,
    parameter int PORT_N   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              halt_stb,
    input  logic              sleep_stb,
    input  logic              bus_req,
    input  logic [IRQ_N-1:0]  irq_pend,
    input  logic [PORT_N-1:0] port_lvl,
    input  logic [PORT_N-1:0] port_msk,
    output logic              en_cpu,
    output logic              en_bcu,
    output logic              en_bus,
    output logic              en_dma,
    output logic              en_fosc,
    output logic              en_presc,
    output logic              en_periph,
    output logic              en_refresh,
    output logic              en_sosc,
    output logic              bus_gnt,
    output logic [2:0]        mode_o
);
    logic              sosc_on, halt_deep, brel_en, wake;
    logic [STAB_W-1:0] stab_len;
    mode_e             mode;
    gate_t             gates;

    stby_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAB_W(STAB_W), .STAB_RST(STAB_RST)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sosc_on(sosc_on), .halt_deep(halt_deep), .brel_en(brel_en), .stab_len(stab_len)
    );

    stby_wake #(.IRQ_N(IRQ_N), .PORT_N(PORT_N)) u_wake (
        .irq_pend(irq_pend), .port_lvl(port_lvl), .port_msk(port_msk), .wake(wake)
    );

    stby_fsm #(.STAB_W(STAB_W)) u_fsm (
        .clk(clk), .rst(rst), .halt_stb(halt_stb), .sleep_stb(sleep_stb),
        .bus_req(bus_req), .brel_en(brel_en), .halt_deep(halt_deep), .wake(wake),
        .stab_len(stab_len), .mode(mode), .bus_gnt(bus_gnt)
    );

    assign gates      = gates_for(mode);
    assign en_cpu     = gates.cpu;
    assign en_bcu     = gates.bcu;
    assign en_bus     = gates.bus;
    assign en_dma     = gates.dma;
    assign en_fosc    = gates.fosc;
    assign en_presc   = gates.presc;
    assign en_periph  = gates.periph;
    assign en_refresh = gates.refresh;
    assign en_sosc    = sosc_on;
    assign mode_o     = mode;
endmodule

// File: rtl/stby_pwr_chk.sv
module stby_pwr_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic       halt_stb,
    input logic       sleep_stb,
    input logic       bus_req,
    input logic       brel_en,
    input logic       halt_deep,
    input logic       wake,
    input logic       bus_gnt,
    input logic       en_fosc,
    input logic       en_presc,
    input logic       en_periph,
    input logic       en_refresh
);
    AST_HALT_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 && halt_stb && !sleep_stb && !wake && !(bus_req && brel_en))
        |=> (mode == ($past(halt_deep) ? 3'd2 : 3'd1))); // R1

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && bus_req) |=> (mode == 3'd1 && bus_gnt)); // R6

    AST_BUS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && !bus_req) |=> (mode == 3'd0 && !bus_gnt)); // R6

    AST_PEND_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 && wake && !(bus_req && brel_en)) |=> (mode == 3'd0)); // R11

    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3) |-> (!en_fosc && !en_presc && !en_periph)); // R5

    AST_NO_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 || mode == 3'd3) |-> !en_refresh); // R4

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && wake) |=> (mode == 3'd4 || mode == 3'd0)); // R10
endmodule

bind stby_pwr_ctrl stby_pwr_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode_o), .halt_stb(halt_stb), .sleep_stb(sleep_stb),
    .bus_req(bus_req), .brel_en(brel_en), .halt_deep(halt_deep), .wake(wake),
    .bus_gnt(bus_gnt), .en_fosc(en_fosc), .en_presc(en_presc),
    .en_periph(en_periph), .en_refresh(en_refresh)
);

// File: tb/sim_stby_pwr_ctrl.sv
module sim_stby_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic       halt_stb = 1'b0, sleep_stb = 1'b0, bus_req = 1'b0;
    logic [7:0] irq_pend = '0;
    logic [3:0] port_lvl = '0, port_msk = '0;
    logic en_cpu, en_bcu, en_bus, en_dma, en_fosc, en_presc, en_periph, en_refresh, en_sosc;
    logic bus_gnt;
    logic [2:0] mode_o;

    always #2.5 clk = ~clk;

    stby_pwr_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .halt_stb(halt_stb), .sleep_stb(sleep_stb), .bus_req(bus_req),
        .irq_pend(irq_pend), .port_lvl(port_lvl), .port_msk(port_msk),
        .en_cpu(en_cpu), .en_bcu(en_bcu), .en_bus(en_bus), .en_dma(en_dma),
        .en_fosc(en_fosc), .en_presc(en_presc), .en_periph(en_periph),
        .en_refresh(en_refresh), .en_sosc(en_sosc), .bus_gnt(bus_gnt), .mode_o(mode_o)
    );

    typedef struct {
        int    mode;
        bit    gnt;
        bit    sosc;
        string req;
    } item_t;

    item_t q[$];
    item_t cur;
    int checks = 0, fails = 0;
    bit sosc_e = 1'b1;
    bit done = 1'b0;

    // Expected {cpu,bcu,bus,dma,fosc,presc,periph,refresh} per mode (R3 R4 R5 R10)
    function automatic logic [7:0] gates_exp(int m);
        case (m)
            0: return 8'b1111_1111;
            1: return 8'b0111_1111;
            2: return 8'b0000_1110;
            3: return 8'b0000_0000;
            4: return 8'b0000_1110;
            default: return 8'hxx;
        endcase
    endfunction

    // Monitor: pops one expected item per clock and compares
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            logic [11:0] act, exp;
            cur = q.pop_front();
            act = {mode_o, en_cpu, en_bcu, en_bus, en_dma, en_fosc, en_presc,
                   en_periph, en_refresh, en_sosc} ^ 12'h0;
            exp = {3'(cur.mode), gates_exp(cur.mode), cur.sosc};
            checks++;
            if (act !== exp || bus_gnt !== cur.gnt) begin
                fails++;
                $display("FAIL %s: actual mode/gates/sosc=%h gnt=%b expected %h gnt=%b",
                         cur.req, act, bus_gnt, exp, cur.gnt);
            end
        end
    end

    // Driver: pushes what the next clock edge must produce
    task automatic tick(int m, bit g, string r);
        item_t it;
        it.mode = m; it.gnt = g; it.sosc = sosc_e; it.req = r;
        q.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d, string r);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(0, 1'b0, r);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick(0, 1'b0, "R2");                       // reset state, sosc on (R9)

        halt_stb = 1'b1; tick(1, 1'b0, "R1");      // default option -> basic halt
        halt_stb = 1'b0; tick(1, 1'b0, "R3");
        irq_pend = 8'h10; tick(0, 1'b0, "R1");     // interrupt wakes
        halt_stb = 1'b1; tick(0, 1'b0, "R11");     // pending blocks halt
        halt_stb = 1'b0; sleep_stb = 1'b1; tick(0, 1'b0, "R11");
        sleep_stb = 1'b0; irq_pend = '0;

        wr(2'd1, 16'h0001, "R4");                  // deep halt selected
        halt_stb = 1'b1; tick(2, 1'b0, "R4");
        halt_stb = 1'b0; tick(2, 1'b0, "R4");
        port_lvl = 4'b0100; tick(2, 1'b0, "R8");   // masked level ignored
        port_msk = 4'b0100; tick(0, 1'b0, "R8");   // unmasked level wakes
        port_lvl = '0; port_msk = '0;

        wr(2'd2, 16'd3, "R10");
        sleep_stb = 1'b1; tick(3, 1'b0, "R5");
        sleep_stb = 1'b0; tick(3, 1'b0, "R5");
        irq_pend = 8'h01; tick(4, 1'b0, "R10");
        irq_pend = '0; tick(4, 1'b0, "R10");
        tick(4, 1'b0, "R10");
        tick(0, 1'b0, "R10");

        wr(2'd2, 16'd0, "R12");
        sleep_stb = 1'b1; halt_stb = 1'b1; tick(3, 1'b0, "R12");
        sleep_stb = 1'b0; halt_stb = 1'b0; irq_pend = 8'h80; tick(0, 1'b0, "R12");
        irq_pend = '0;

        bus_req = 1'b1; tick(0, 1'b0, "R7");       // release not enabled
        tick(0, 1'b0, "R7");
        bus_req = 1'b0;
        wr(2'd1, 16'h0002, "R6");
        bus_req = 1'b1; tick(1, 1'b1, "R6");
        irq_pend = 8'h02; tick(1, 1'b1, "R6");     // interrupt does not end it
        irq_pend = '0; tick(1, 1'b1, "R6");
        bus_req = 1'b0; tick(0, 1'b0, "R6");

        sosc_e = 1'b0; wr(2'd0, 16'h0000, "R9");
        sleep_stb = 1'b1; tick(3, 1'b0, "R9");
        sleep_stb = 1'b0; irq_pend = 8'h04; tick(0, 1'b0, "R9");
        irq_pend = '0;
        sosc_e = 1'b1; wr(2'd0, 16'h0001, "R9");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule